// File: doc/BRIEF.md
# Delayed Triggered Pulse Generator

This block is one pulse channel that runs on the event clock. A one-cycle trigger strobe starts a programmable delay. When the delay has run out, the channel raises its pulse level and starts a programmable width count. When that count has run out, the level drops again. An optional prescaler slows the rate at which both counts advance. The prescaler is present when `PSC_W` is 16 and absent when `PSC_W` is 0.

Two further strobes drive the level directly, one setting it and one clearing it. Two enables, a master one and a software one, must both be high for the channel to act. A polarity input inverts the level before it reaches the pin. All settings arrive as plain register inputs that the host logic holds steady. Producing the strobes and decoding the register bus are left to the surrounding logic.

Top module: `trig_pulse_chan`

## Requirements
- R1: With the channel idle and enabled, a trigger sampled at clock edge E0, with delay value `dly_val` > 0, makes the level go active just after edge E0 + dly_val*P. P is the effective tick period from R5.
- R2: After going active through R1 or R3, the level stays active for exactly wid_val*P cycles and then returns inactive.
- R3: A delay value of 0 makes the level go active just after the edge at which the trigger is sampled.
- R4: A trigger taken while `wid_val` is 0 is ignored. No pulse appears and the channel stays idle.
- R5: The counts advance once every P cycles. P is `psc_div` when `psc_div` > 1, and P is 1 when `psc_div` is 0 or 1. The phase of the prescaler restarts at the accepted trigger. In a build with `PSC_W` = 0 the prescaler is absent and P is always 1.
- R6: A trigger that arrives while a delay or width count is in progress is ignored. The pulse in progress keeps its timing.
- R7: While enabled, `force_hi` sets the level and `force_lo` clears it on the next edge. These strobes take precedence over count events in the same cycle and leave the running count untouched.
- R8: When `force_hi` and `force_lo` are high in the same cycle, the level is cleared.
- R9: The channel acts only when both `mst_en` and `sw_en` are 1. Otherwise, from the next edge on, the level is inactive, any count in progress is abandoned, and triggers and force strobes are ignored.
- R10: `pulse_out` equals the level XOR `invert`, so `invert` = 1 makes the inactive state high.
- R11: During and right after reset, the level is inactive and the channel is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Event clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mst_en | input | 1 | Master enable |
| sw_en | input | 1 | Software enable |
| invert | input | 1 | Output polarity: 1 inverts the level |
| trig | input | 1 | One-cycle trigger strobe |
| force_hi | input | 1 | Strobe that sets the level |
| force_lo | input | 1 | Strobe that clears the level; wins over force_hi |
| dly_val | input | DLY_W | Delay in prescaler ticks |
| wid_val | input | WID_W | Width in prescaler ticks |
| psc_div | input | PSC_PW | Prescaler divisor (0 and 1 mean undivided) |
| pulse_out | output | 1 | Pulse output after polarity |

## Verification
A wrong count or a prescaler phase that slips shows at `pulse_out` as an edge moved by at least one cycle. The start edge moves within delay*P cycles of the trigger, and the end edge within (delay+width)*P. A channel stuck busy shows up on the next trigger, which then produces no pulse. A level stage that ignores the enables or the forces differs at the pin one cycle after the strobe. The bench compares the pin against a timeline model on every cycle. It does this for a prescaled build and a build without a prescaler at the same time, so any such slip is flagged in the cycle where it first appears.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_DELAY = 2'd1,
        PH_WIDTH = 2'd2
    } tpg_phase_e;

endpackage

// File: rtl/tpg_tick_gen.sv
module tpg_tick_gen #(
    parameter int PSC_W  = 16,
    parameter int PSC_PW = (PSC_W > 0) ? PSC_W : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSC_PW-1:0] div,
    output logic              tick
);

    generate
        if (PSC_W == 0) begin : g_bypass
            logic unused_bypass;
            assign unused_bypass = ^{clk, rst_n, run, div};
            assign tick = 1'b1;
        end else begin : g_div
            localparam logic [PSC_W-1:0] ONE = PSC_W'(1);
            logic [PSC_W-1:0] cnt_d, cnt_q;
            logic             undiv;
            logic             wrap;

            always_comb begin
                undiv = (div <= ONE);
                wrap  = undiv || (cnt_q == div - ONE);
                cnt_d = cnt_q;
                if (!run) begin
                    cnt_d = '0;
                end else if (wrap) begin
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt_q <= '0;
                end else begin
                    cnt_q <= cnt_d;
                end
            end

            assign tick = run && wrap;

            // R5: the phase is held at zero while no count runs
            a_r5_idle_phase_zero: assert property (@(posedge clk) disable iff (!rst_n)
                !run |=> (cnt_q == '0));
        end
    endgenerate

endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
    import tpg_pkg::*;
#(
    parameter int DLY_W = 32,
    parameter int WID_W = 32,
    parameter int CW    = (DLY_W > WID_W) ? DLY_W : WID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             trig,
    input  logic             tick,
    input  logic [DLY_W-1:0] dly,
    input  logic [WID_W-1:0] wid,
    output logic             busy,
    output logic             set_evt,
    output logic             clr_evt
);

    localparam logic [CW-1:0] CNT_ONE = CW'(1);

    typedef struct packed {
        tpg_phase_e    phase;
        logic [CW-1:0] cnt;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        set_evt = 1'b0;
        clr_evt = 1'b0;
        if (!en) begin
            st_d.phase = PH_IDLE;
            st_d.cnt   = '0;
        end else begin
            unique case (st_q.phase)
                PH_IDLE: begin
                    if (trig && (wid != '0)) begin
                        if (dly == '0) begin
                            set_evt    = 1'b1;
                            st_d.phase = PH_WIDTH;
                            st_d.cnt   = CW'(wid);
                        end else begin
                            st_d.phase = PH_DELAY;
                            st_d.cnt   = CW'(dly);
                        end
                    end
                end
                PH_DELAY: begin
                    if (tick) begin
                        if (st_q.cnt == CNT_ONE) begin
                            if (wid != '0) begin
                                set_evt    = 1'b1;
                                st_d.phase = PH_WIDTH;
                                st_d.cnt   = CW'(wid);
                            end else begin
                                st_d.phase = PH_IDLE;
                                st_d.cnt   = '0;
                            end
                        end else begin
                            st_d.cnt = st_q.cnt - CNT_ONE;
                        end
                    end
                end
                PH_WIDTH: begin
                    if (tick) begin
                        if (st_q.cnt == CNT_ONE) begin
                            clr_evt    = 1'b1;
                            st_d.phase = PH_IDLE;
                            st_d.cnt   = '0;
                        end else begin
                            st_d.cnt = st_q.cnt - CNT_ONE;
                        end
                    end
                end
                default: begin
                    st_d.phase = PH_IDLE;
                    st_d.cnt   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.phase != PH_IDLE);

    // R1: the last delay tick hands over to the width count
    a_r1_delay_to_width: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.phase == PH_DELAY && tick && st_q.cnt == CNT_ONE && wid != '0)
        |=> (st_q.phase == PH_WIDTH));

    // R5: without a tick a running count does not move
    a_r5_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.phase != PH_IDLE && !tick) |=> $stable(st_q.cnt));

    // R4: a trigger with zero width leaves the channel idle
    a_r4_zero_width_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (en && st_q.phase == PH_IDLE && wid == '0) |=> (st_q.phase == PH_IDLE));

    // R9: dropping an enable abandons the count
    a_r9_disable_idles: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (st_q.phase == PH_IDLE));

endmodule

// File: rtl/tpg_level.sv
module tpg_level (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic set_evt,
    input  logic clr_evt,
    input  logic force_hi,
    input  logic force_lo,
    output logic lvl
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (!en) begin
            lvl_d = 1'b0;
        end else begin
            if (set_evt)  lvl_d = 1'b1;
            if (clr_evt)  lvl_d = 1'b0;
            if (force_hi) lvl_d = 1'b1;
            if (force_lo) lvl_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign lvl = lvl_q;

    // R8: a clear strobe always leaves the level low
    a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (en && force_lo) |=> !lvl_q);

    // R7: a lone set strobe leaves the level high
    a_r7_set_forces: assert property (@(posedge clk) disable iff (!rst_n)
        (en && force_hi && !force_lo) |=> lvl_q);

    // R9: while disabled the level is inactive
    a_r9_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !lvl_q);

endmodule

// File: rtl/trig_pulse_chan.sv
module trig_pulse_chan #(
    parameter int DLY_W  = 32,
    parameter int WID_W  = 32,
    parameter int PSC_W  = 16,
    parameter int PSC_PW = (PSC_W > 0) ? PSC_W : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mst_en,
    input  logic              sw_en,
    input  logic              invert,
    input  logic              trig,
    input  logic              force_hi,
    input  logic              force_lo,
    input  logic [DLY_W-1:0]  dly_val,
    input  logic [WID_W-1:0]  wid_val,
    input  logic [PSC_PW-1:0] psc_div,
    output logic              pulse_out
);

    logic en;
    logic busy;
    logic tick;
    logic set_evt;
    logic clr_evt;
    logic lvl;

    assign en = mst_en & sw_en;

    tpg_tick_gen #(
        .PSC_W  (PSC_W),
        .PSC_PW (PSC_PW)
    ) tick_i (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (busy),
        .div  (psc_div),
        .tick (tick)
    );

    tpg_seq #(
        .DLY_W(DLY_W),
        .WID_W(WID_W)
    ) seq_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (en),
        .trig   (trig),
        .tick   (tick),
        .dly    (dly_val),
        .wid    (wid_val),
        .busy   (busy),
        .set_evt(set_evt),
        .clr_evt(clr_evt)
    );

    tpg_level lvl_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .set_evt (set_evt),
        .clr_evt (clr_evt),
        .force_hi(force_hi),
        .force_lo(force_lo),
        .lvl     (lvl)
    );

    assign pulse_out = lvl ^ invert;

endmodule

// File: tb/trig_pulse_chan_tb_top.sv
module trig_pulse_chan_tb_top;

    localparam int DLY_W = 32;
    localparam int WID_W = 16;
    localparam int PSC_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mst_en = 1'b0;
    logic              sw_en = 1'b0;
    logic              invert = 1'b0;
    logic              trig = 1'b0;
    logic              force_hi = 1'b0;
    logic              force_lo = 1'b0;
    logic [DLY_W-1:0]  dly_val = '0;
    logic [WID_W-1:0]  wid_val = '0;
    logic [PSC_W-1:0]  psc_div = '0;
    logic              out_a;
    logic              out_b;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R11";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    trig_pulse_chan #(.DLY_W(DLY_W), .WID_W(WID_W), .PSC_W(PSC_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .sw_en(sw_en), .invert(invert),
        .trig(trig), .force_hi(force_hi), .force_lo(force_lo),
        .dly_val(dly_val), .wid_val(wid_val), .psc_div(psc_div), .pulse_out(out_a)
    );

    trig_pulse_chan #(.DLY_W(DLY_W), .WID_W(WID_W), .PSC_W(0)) dut_nopsc_i (
        .clk(clk), .rst_n(rst_n), .mst_en(mst_en), .sw_en(sw_en), .invert(invert),
        .trig(trig), .force_hi(force_hi), .force_lo(force_lo),
        .dly_val(dly_val), .wid_val(wid_val), .psc_div(1'b0), .pulse_out(out_b)
    );

    // Timeline model: each accepted trigger gets absolute on/off cycles
    longint cyc = 0;
    bit     m_lvl [2];
    bit     m_busy[2];
    longint m_on  [2];
    longint m_off [2];

    always @(posedge clk) begin
        cyc = cyc + 1;
        for (int k = 0; k < 2; k++) begin
            longint p;
            p = (k == 1 || psc_div <= 1) ? 1 : longint'(psc_div);
            if (!rst_n || !(mst_en && sw_en)) begin
                m_lvl[k]  = 1'b0;
                m_busy[k] = 1'b0;
            end else begin
                if (trig && !m_busy[k] && wid_val != 0) begin
                    m_busy[k] = 1'b1;
                    m_on[k]   = cyc + longint'(dly_val) * p;
                    m_off[k]  = cyc + (longint'(dly_val) + longint'(wid_val)) * p;
                end
                if (m_busy[k] && cyc == m_on[k]) m_lvl[k] = 1'b1;
                if (m_busy[k] && cyc == m_off[k]) begin
                    m_lvl[k]  = 1'b0;
                    m_busy[k] = 1'b0;
                end
                if (force_hi) m_lvl[k] = 1'b1;
                if (force_lo) m_lvl[k] = 1'b0;
            end
        end
    end

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", req, what, cyc, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            check(cur_req, out_a, m_lvl[0] ^ invert, "prescaled build");
            check(cur_req, out_b, m_lvl[1] ^ invert, "undivided build");
        end
    end

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
        #1;
    endtask

    task automatic strobe(input bit t, input bit fh, input bit fl);
        trig = t; force_hi = fh; force_lo = fl;
        @(negedge clk); #1;
        trig = 1'b0; force_hi = 1'b0; force_lo = 1'b0;
    endtask

    task automatic setup(input int d, input int w, input int p);
        dly_val = DLY_W'(d);
        wid_val = WID_W'(w);
        psc_div = PSC_W'(p);
    endtask

    initial begin
        // R11: reset state
        idle(3);
        check("R11", out_a, 1'b0, "level in reset");
        rst_n = 1'b1; mst_en = 1'b1; sw_en = 1'b1;
        idle(2);
        check("R11", out_b, 1'b0, "level after reset");

        cur_req = "R1";   setup(3, 4, 0); strobe(1, 0, 0); idle(12);
        cur_req = "R2";   setup(5, 7, 1); strobe(1, 0, 0); idle(16);
        cur_req = "R3";   setup(0, 2, 0); strobe(1, 0, 0); idle(6);
        cur_req = "R3";   setup(0, 1, 4); strobe(1, 0, 0); idle(8);
        cur_req = "R4";   setup(2, 0, 0); strobe(1, 0, 0); idle(8);
        check("R4", out_a, 1'b0, "no pulse for zero width");
        cur_req = "R5";   setup(2, 3, 3); strobe(1, 0, 0); idle(20);
        cur_req = "R5";   setup(1, 2, 5); strobe(1, 0, 0); idle(20);
        cur_req = "R6";   setup(5, 5, 0); strobe(1, 0, 0); idle(2);
        strobe(1, 0, 0); idle(4); strobe(1, 0, 0); idle(8);
        cur_req = "R6";   setup(2, 2, 2); strobe(1, 0, 0); idle(5); strobe(1, 0, 0); idle(10);
        cur_req = "R7";   setup(4, 3, 0); strobe(0, 1, 0); idle(3); strobe(0, 0, 1); idle(2);
        strobe(1, 0, 0); strobe(0, 1, 0); idle(9);
        strobe(1, 0, 0); idle(4); strobe(0, 0, 1); idle(5);
        cur_req = "R8";   strobe(0, 1, 0); idle(1); strobe(0, 1, 1); idle(2);
        check("R8", out_a, 1'b0, "set with clear");
        cur_req = "R9";   mst_en = 1'b0; strobe(1, 0, 0); strobe(0, 1, 0); idle(10);
        check("R9", out_a, 1'b0, "master enable off");
        mst_en = 1'b1; sw_en = 1'b0; strobe(1, 0, 0); strobe(0, 1, 0); idle(10);
        sw_en = 1'b1; setup(1, 8, 0); strobe(1, 0, 0); idle(4);
        sw_en = 1'b0; idle(3); sw_en = 1'b1; idle(10);
        cur_req = "R10";  invert = 1'b1; idle(2);
        check("R10", out_a, 1'b1, "inverted idle level");
        setup(2, 3, 2); strobe(1, 0, 0); idle(14);
        mst_en = 1'b0; idle(3);
        check("R10", out_b, 1'b1, "inverted disabled level");
        mst_en = 1'b1; invert = 1'b0; idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule